// File: doc/BRIEF.md
# Prioritized Memory and I/O Chip-Select Decoder

This block drives four active-low chip-select lines from a 24-bit bus address and two cycle qualifiers, one marking a memory access and one marking an I/O instruction. Each channel holds four settings: an enable bit, a mode bit choosing memory or I/O space, a lower-bound byte and an upper-bound byte. Software loads them through a byte-wide write port. A channel in memory mode fires when the top address byte lies inside its inclusive bounds. A channel in I/O mode fires when the middle address byte equals its lower bound.

When several channels qualify, only the lowest-numbered one is driven. I/O addresses 0080h through 00FFh belong to on-chip peripherals. There no I/O chip select fires and a separate flag reports the hit instead. The chip-select outputs are combinational in the current address and cycle type. Only the configuration is registered.

Top module: `csel_decoder`

## Requirements
- R1: While reset is applied and directly after it, every channel is disabled and all of `cs_n` stays high whatever the address and cycle inputs are.
- R2: A channel whose control byte has bit 0 (enable) set and bit 1 (I/O mode) clear drives its `cs_n` bit low during a memory cycle when `bus_addr[23:16]` is at least its lower bound and at most its upper bound. Both bounds are included.
- R3: A channel with enable and I/O-mode both set fires during an I/O cycle when `bus_addr[15:8]` equals its lower bound. `bus_addr[23:16]` and the upper bound have no effect on this.
- R4: An I/O-mode channel never fires on a memory cycle. A memory-mode channel never fires on an I/O cycle.
- R5: During an I/O cycle with `bus_addr[15:0]` between 0080h and 00FFh inclusive, `periph_hit` is high and all of `cs_n` is high. `periph_hit` is low in every other case.
- R6: When more than one channel qualifies, only the lowest-numbered one drives its `cs_n` bit low. At most one `cs_n` bit is low at any time.
- R7: When neither `mem_cyc` nor `io_cyc` is high, all of `cs_n` is high.
- R8: A write with `cfg_we` high updates the field of channel `cfg_ch` chosen by `cfg_field` (0 = control byte, 1 = lower bound, 2 = upper bound) at the next clock edge. Code 3 changes nothing. The other fields and the other channels keep their values.
- R9: A channel whose enable bit is clear never fires, whatever its bounds and mode.
- R10: `cs_n` and `periph_hit` follow `bus_addr`, `mem_cyc` and `io_cyc` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected for the write |
| cfg_field | input | 2 | Field code: 0 control, 1 lower bound, 2 upper bound, 3 no-op |
| cfg_wdata | input | 8 | Write data; for the control byte, bit 0 is enable and bit 1 is I/O mode |
| bus_addr | input | 24 | Current bus address |
| mem_cyc | input | 1 | High during a memory access |
| io_cyc | input | 1 | High during an I/O instruction |
| cs_n | output | 4 | Active-low chip selects, bit i for channel i |
| periph_hit | output | 1 | High when an I/O cycle targets the on-chip peripheral window |

## Verification
The assertions assume that `mem_cyc` and `io_cyc` are never high together, because the bus marks each cycle as one kind only. The bench keeps to this: every access it drives raises at most one of the two qualifiers.

The assertions also assume that configuration writes arrive as single-cycle strobes with stable channel and field codes. The bench drives each write for exactly one clock. It then holds `cfg_we` low while it applies the address patterns that depend on that write.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef struct packed {
        logic       en;
        logic       io;
        logic [7:0] lo;
        logic [7:0] hi;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_LO   = 2'd1,
        FLD_HI   = 2'd2,
        FLD_NONE = 2'd3
    } cfg_field_e;

    localparam logic [8:0] PERIPH_PAGE = 9'b0_0000_0001;

endpackage

// File: rtl/csel_cfg.sv
module csel_cfg
    import csel_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CH_W = $clog2(N_CH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [CH_W-1:0]           ch,
    input  logic [1:0]                field,
    input  logic [7:0]                wdata,
    output chan_cfg_t [N_CH-1:0]      cfg_o
);

    typedef struct packed {
        chan_cfg_t [N_CH-1:0] chan;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       ch_ok;

    assign ch_ok = ({{(32-CH_W){1'b0}}, ch} < N_CH);

    always_comb begin
        st_d = st_q;
        if (we && ch_ok) begin
            case (cfg_field_e'(field))
                FLD_CTRL: begin
                    st_d.chan[ch].en = wdata[0];
                    st_d.chan[ch].io = wdata[1];
                end
                FLD_LO:   st_d.chan[ch].lo = wdata;
                FLD_HI:   st_d.chan[ch].hi = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.chan;

    AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ch_ok && field == 2'd1) |=> (cfg_o[$past(ch)].lo == $past(wdata))); // R8
    AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ch_ok && field == 2'd2) |=> (cfg_o[$past(ch)].hi == $past(wdata))); // R8
    AST_NOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || field == 2'd3) |=> $stable(cfg_o)); // R8

endmodule

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  chan_cfg_t [N_CH-1:0]  cfg,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  mem_cyc,
    input  logic                  io_cyc,
    output logic [N_CH-1:0]       hit,
    output logic                  periph
);

    localparam int TOP_LSB  = ADDR_W - 8;
    localparam int PAGE_LSB = 8;

    logic [7:0] top_byte;
    logic [7:0] io_page;

    assign top_byte = addr[ADDR_W-1:TOP_LSB];
    assign io_page  = addr[PAGE_LSB+7:PAGE_LSB];
    assign periph   = io_cyc && (addr[15:7] == PERIPH_PAGE);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic mem_in, io_in;
        always_comb begin
            mem_in = mem_cyc && !cfg[i].io
                   && (top_byte >= cfg[i].lo) && (top_byte <= cfg[i].hi);
            io_in  = io_cyc && cfg[i].io && !periph
                   && (io_page == cfg[i].lo);
            hit[i] = cfg[i].en && (mem_in || io_in);
        end

        AST_IO_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && cfg[i].io) |-> io_cyc); // R4
        AST_MEM_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && !cfg[i].io) |-> mem_cyc); // R4
        AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[i].en |-> !hit[i]); // R9
    end

endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] req,
    output logic [N_CH-1:0] grant
);

    logic taken;

    always_comb begin
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N_CH; i++) begin
            grant[i] = req[i] && !taken;
            taken    = taken || req[i];
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_GRANT_IFF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) == (|grant)); // R6

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
    import csel_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 24,
    parameter int CH_W   = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_field,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              mem_cyc,
    input  logic              io_cyc,
    output logic [N_CH-1:0]   cs_n,
    output logic              periph_hit
);

    chan_cfg_t [N_CH-1:0] cfg;
    logic [N_CH-1:0]      hit;
    logic [N_CH-1:0]      grant;

    csel_cfg #(.N_CH(N_CH), .CH_W(CH_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .ch    (cfg_ch),
        .field (cfg_field),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    csel_match #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .addr    (bus_addr),
        .mem_cyc (mem_cyc),
        .io_cyc  (io_cyc),
        .hit     (hit),
        .periph  (periph_hit)
    );

    csel_prio #(.N_CH(N_CH)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (hit),
        .grant (grant)
    );

    assign cs_n = ~grant;

    AST_PERIPH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        periph_hit |-> (&cs_n)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cyc && !io_cyc) |-> ((&cs_n) && !periph_hit)); // R7
    AST_PERIPH_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        periph_hit |-> io_cyc); // R5

endmodule

// File: tb/csel_decoder_bench.sv
module csel_decoder_bench;

    localparam int N_CH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [1:0]  cfg_field = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:0] bus_addr = '0;
    logic        mem_cyc = 1'b0;
    logic        io_cyc = 1'b0;
    logic [3:0]  cs_n;
    logic        periph_hit;

    always #2 clk = ~clk;

    csel_decoder u_csel_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_ch     (cfg_ch),
        .cfg_field  (cfg_field),
        .cfg_wdata  (cfg_wdata),
        .bus_addr   (bus_addr),
        .mem_cyc    (mem_cyc),
        .io_cyc     (io_cyc),
        .cs_n       (cs_n),
        .periph_hit (periph_hit)
    );

    typedef struct {
        logic [3:0] cs_exp;
        logic       ph_exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    logic       sh_en[N_CH];
    logic       sh_io[N_CH];
    logic [7:0] sh_lo[N_CH];
    logic [7:0] sh_hi[N_CH];

    task automatic shadow_clear();
        for (int i = 0; i < N_CH; i++) begin
            sh_en[i] = 1'b0; sh_io[i] = 1'b0; sh_lo[i] = '0; sh_hi[i] = '0;
        end
    endtask

    function automatic void model(input logic [23:0] a, input logic m, input logic io,
                                  output logic [3:0] cs, output logic ph);
        logic won;
        ph  = io && (a[15:0] >= 16'h0080) && (a[15:0] <= 16'h00FF);
        cs  = 4'hF;
        won = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            logic ok;
            ok = sh_en[i] && (
                   (m && !sh_io[i] && a[23:16] >= sh_lo[i] && a[23:16] <= sh_hi[i]) ||
                   (io && sh_io[i] && !ph && a[15:8] == sh_lo[i]));
            if (ok && !won) begin
                cs[i] = 1'b0;
                won   = 1'b1;
            end
        end
    endfunction

    task automatic wr(input int ch, input int fld, input logic [7:0] d);
        @(negedge clk);
        mem_cyc = 1'b0; io_cyc = 1'b0;
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_field = 2'(fld); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (fld)
            0: begin sh_en[ch] = d[0]; sh_io[ch] = d[1]; end
            1: sh_lo[ch] = d;
            2: sh_hi[ch] = d;
            default: ;
        endcase
    endtask

    task automatic drive(input logic [23:0] a, input logic m, input logic io, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a; mem_cyc = m; io_cyc = io;
        model(a, m, io, it.cs_exp, it.ph_exp);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic setup(input int ch, input logic [7:0] ctrl, input logic [7:0] lo, input logic [7:0] hi);
        wr(ch, 1, lo);
        wr(ch, 2, hi);
        wr(ch, 0, ctrl);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (cs_n !== it.cs_exp || periph_hit !== it.ph_exp) begin
                    n_bad++;
                    $display("FAIL %s: cs_n=%b periph_hit=%b expected cs_n=%b periph_hit=%b",
                             it.tag, cs_n, periph_hit, it.cs_exp, it.ph_exp);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        shadow_clear();
        // R1: reset state
        drive(24'h123456, 1'b1, 1'b0, "R1 reset mem");
        drive(24'h004100, 1'b0, 1'b1, "R1 reset io");
        @(negedge clk);
        rst_n = 1'b1;
        drive(24'h800000, 1'b1, 1'b0, "R1 after reset");

        // R2: partitioned memory map, boundaries
        setup(0, 8'h01, 8'h00, 8'h7F);
        setup(1, 8'h01, 8'h80, 8'h9F);
        setup(2, 8'h01, 8'hA0, 8'hCF);
        setup(3, 8'h01, 8'hD0, 8'hFF);
        drive(24'h000000, 1'b1, 1'b0, "R2 low edge ch0");
        drive(24'h7FFFFF, 1'b1, 1'b0, "R2 high edge ch0");
        drive(24'h800000, 1'b1, 1'b0, "R2 low edge ch1");
        drive(24'h9FFFFF, 1'b1, 1'b0, "R2 high edge ch1");
        drive(24'hA00000, 1'b1, 1'b0, "R2 low edge ch2");
        drive(24'hCFFFFF, 1'b1, 1'b0, "R2 high edge ch2");
        drive(24'hD00000, 1'b1, 1'b0, "R2 low edge ch3");
        drive(24'hFFFFFF, 1'b1, 1'b0, "R2 high edge ch3");
        // R10: back-to-back address changes seen in the same cycle
        drive(24'h000010, 1'b1, 1'b0, "R10 swap a");
        drive(24'hE00010, 1'b1, 1'b0, "R10 swap b");
        // R7: idle
        drive(24'h800000, 1'b0, 1'b0, "R7 idle");
        drive(24'h000090, 1'b0, 1'b0, "R7 idle periph addr");
        // R4: memory channels ignore io cycles
        drive(24'h80A000, 1'b0, 1'b1, "R4 io on mem channels");

        // R6: overlapping ranges
        setup(2, 8'h01, 8'h00, 8'hFF);
        drive(24'h100000, 1'b1, 1'b0, "R6 ch0 beats ch2");
        drive(24'h900000, 1'b1, 1'b0, "R6 ch1 beats ch2");
        drive(24'hE00000, 1'b1, 1'b0, "R6 ch2 beats ch3");

        // R9/R8: disable ch0 via control write
        wr(0, 0, 8'h00);
        drive(24'h100000, 1'b1, 1'b0, "R9 ch0 disabled");
        wr(1, 0, 8'h00);
        drive(24'h900000, 1'b1, 1'b0, "R9 ch1 disabled");

        // R3: io page match on ch3, top byte ignored
        setup(3, 8'h03, 8'h40, 8'h00);
        drive(24'hAB4012, 1'b0, 1'b1, "R3 io page hit top ignored");
        drive(24'h0040FF, 1'b0, 1'b1, "R3 io page hit");
        drive(24'h004100, 1'b0, 1'b1, "R3 io page miss");
        // R4: io channel ignores memory cycles (ch2 covers it)
        drive(24'h400000, 1'b1, 1'b0, "R4 mem on io channel");

        // R5: peripheral window against an io channel on page 00
        setup(1, 8'h03, 8'h00, 8'hFF);
        drive(24'h000080, 1'b0, 1'b1, "R5 window low edge");
        drive(24'h0000FF, 1'b0, 1'b1, "R5 window high edge");
        drive(24'h550090, 1'b0, 1'b1, "R5 window top ignored");
        drive(24'h00007F, 1'b0, 1'b1, "R5 below window page 00");
        drive(24'h000100, 1'b0, 1'b1, "R5 above window");
        drive(24'h000090, 1'b1, 1'b0, "R5 mem cycle no periph");

        // R8: field code 3 is a no-op; lower bound rewrite moves page
        wr(3, 3, 8'h00);
        drive(24'h004055, 1'b0, 1'b1, "R8 nop field keeps ch3");
        wr(3, 1, 8'h41);
        drive(24'h004055, 1'b0, 1'b1, "R8 old page dropped");
        drive(24'h004155, 1'b0, 1'b1, "R8 new page taken");
        drive(24'hC00000, 1'b1, 1'b0, "R8 ch2 untouched");

        // R1: reset again clears all
        @(negedge clk);
        rst_n = 1'b0;
        shadow_clear();
        drive(24'h004155, 1'b0, 1'b1, "R1 re-reset io");
        drive(24'hC00000, 1'b1, 1'b0, "R1 re-reset mem");
        @(negedge clk);
        rst_n = 1'b1;
        drive(24'hC00000, 1'b1, 1'b0, "R1 after re-reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule